// File: doc/BRIEF.md
# Timer Clock Tick Tree

This block turns one peripheral clock into five independent count-enable ticks for a five-channel timer unit. Two programmable prescalers divide the peripheral clock. The first serves timers 0 and 1. The second serves timers 2, 3 and 4. Each timer then applies its own power-of-two divider to its prescaler's ticks.

Each timer's select field can instead route one of two external clock pins to that timer. Each pin is first brought into the peripheral clock domain through a synchroniser. Every output is a one-cycle enable pulse in the peripheral clock domain, not a generated clock.

Configuration arrives through a plain write port. The port reaches two 32-bit words: a prescale word and a select word. A per-nibble write enable lets software change one timer's field, or one half of one prescale value, without disturbing any other field. The port has no handshake; a write takes effect at the clock edge on which `cfg_we` is sampled high.

Top module: `timer_tick_tree`

## Requirements
- R1: While `rst_n` is low, `tick_o` is all zero. Reset clears both prescale values and every select field. After reset is released, every timer therefore ticks at the second rising edge and then every 2 cycles.
- R2: The prescale word (`cfg_addr`=0) holds prescaler A in bits [7:0] and prescaler B in bits [15:8]. A prescaler programmed with P emits one tick every P+1 clock cycles, for every P from 0 to 255.
- R3: A select-field code c in the range 0 to 3 divides the timer's prescaler ticks by 2^(c+1). The timer's period in clock cycles is then (P+1)*2^(c+1).
- R4: Timers 0 and 1 take prescaler A and external pin 0. Timers 2, 3 and 4 take prescaler B and external pin 1. A pin or prescaler never affects the other group.
- R5: The select word (`cfg_addr`=1) holds timer t's 4-bit field in bits [4t+3:4t]. Any code from 4 to 15 routes the external pin instead of the divider. While that pin is quiet, the timer emits no ticks.
- R6: In external mode, each rising edge of the pin produces exactly one single-cycle tick, however long the pin stays high. The tick appears in the cycle after the third rising clock edge following the pin's change.
- R7: `cfg_nib_en[i]` enables writing bits [4i+3:4i] of the addressed word. Fields whose nibbles are not enabled keep their values, so the other timers' periods are unchanged.
- R8: A write that touches a timer's select field restarts that timer's divider from zero. A write that touches a prescale value restarts that prescaler and every divider it feeds. The first tick after such a write follows the new ratio. Example: with P=0 and code 1, the first tick is visible after the fourth rising edge following the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Word select: 0 selects the prescale word, 1 selects the select word |
| cfg_nib_en | input | 8 | Per-nibble write enable |
| cfg_wdata | input | 32 | Write data |
| ext_clk_in | input | 2 | Asynchronous external timer clocks (pin 0, pin 1) |
| tick_o | output | 5 | One-cycle count-enable pulse per timer |

## Verification
The hardest situations to reach from the ports are a partial-nibble write and a prescale value near its upper end. A partial-nibble write must leave some fields of a shared word alone while it restarts exactly the counters it touched. A prescale value near 255 combined with the largest divider stretches a timer's period into the thousands of cycles.

The bench sweeps every divider code on every timer against several pairs of unequal prescale values. It then measures the spacing between ticks rather than their phase. Single-nibble writes are issued between measurements, so a field or counter that was disturbed shows up as a changed period. External pulses are applied to one pin at a time, and the bench counts ticks on all five outputs.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_NUM_TMR   = 5;
  localparam int TT_NUM_PRE   = 2;
  localparam int TT_PRE_W     = 8;
  localparam int TT_SEL_W     = 4;
  localparam int TT_DCODE_W   = 2;
  localparam int TT_GRP0_SIZE = 2;
  localparam int TT_DATA_W    = 32;
  localparam int TT_EXT_CODE  = 4;
endpackage

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs #(
  parameter int NUM_TMR = tt_pkg::TT_NUM_TMR,
  parameter int NUM_PRE = tt_pkg::TT_NUM_PRE,
  parameter int PRE_W   = tt_pkg::TT_PRE_W,
  parameter int SEL_W   = tt_pkg::TT_SEL_W,
  parameter int DATA_W  = tt_pkg::TT_DATA_W,
  localparam int NIB_W  = DATA_W / 4,
  localparam int PW     = NUM_PRE * PRE_W,
  localparam int SW     = NUM_TMR * SEL_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic                            addr,
  input  logic [NIB_W-1:0]                nib_en,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_PRE-1:0][PRE_W-1:0]   pre_val,
  output logic [NUM_TMR-1:0][SEL_W-1:0]   sel_val,
  output logic [NUM_PRE-1:0]              pre_clr,
  output logic [NUM_TMR-1:0]              sel_clr
);
  logic [DATA_W-1:0] wmask;
  logic [PW-1:0]     pre_word;
  logic [SW-1:0]     sel_word;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) wmask[i] = nib_en[i/4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_word <= '0;
      sel_word <= '0;
    end else if (we) begin
      if (!addr) pre_word <= (pre_word & ~wmask[PW-1:0]) | (wdata[PW-1:0] & wmask[PW-1:0]);
      else       sel_word <= (sel_word & ~wmask[SW-1:0]) | (wdata[SW-1:0] & wmask[SW-1:0]);
    end
  end

  for (genvar p = 0; p < NUM_PRE; p++) begin : g_pre
    assign pre_val[p] = pre_word[p*PRE_W +: PRE_W];
    assign pre_clr[p] = we && !addr && (|wmask[p*PRE_W +: PRE_W]);
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_sel
    assign sel_val[t] = sel_word[t*SEL_W +: SEL_W];
    assign sel_clr[t] = we && addr && (|wmask[t*SEL_W +: SEL_W]);
  end
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int W = tt_pkg::TT_PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt;

  assign tick  = (cnt == limit);
  assign cnt_o = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tt_ext_sync.sv
module tt_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 && !s3;
endmodule

// File: rtl/tt_chan.sv
module tt_chan #(
  parameter int SEL_W    = tt_pkg::TT_SEL_W,
  parameter int DCODE_W  = tt_pkg::TT_DCODE_W,
  parameter int EXT_CODE = tt_pkg::TT_EXT_CODE,
  localparam int DIV_W   = 2 ** DCODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] code,
  input  logic             pre_tick,
  input  logic             ext_rise,
  output logic             tick_q
);
  logic             ext_mode;
  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] term;
  logic             div_hit;

  assign ext_mode = (code >= SEL_W'(EXT_CODE));
  assign term     = DIV_W'((32'd2 << code[DCODE_W-1:0]) - 32'd1);
  assign div_hit  = pre_tick && (dcnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      tick_q <= 1'b0;
    end else if (clr) begin
      dcnt   <= '0;
      tick_q <= 1'b0;
    end else if (ext_mode) begin
      dcnt   <= '0;
      tick_q <= ext_rise;
    end else begin
      if (pre_tick) dcnt <= div_hit ? '0 : dcnt + 1'b1;
      tick_q <= div_hit;
    end
  end
endmodule

// File: rtl/timer_tick_tree.sv
module timer_tick_tree #(
  parameter int NUM_TMR   = tt_pkg::TT_NUM_TMR,
  parameter int PRE_W     = tt_pkg::TT_PRE_W,
  parameter int GRP0_SIZE = tt_pkg::TT_GRP0_SIZE,
  localparam int NUM_PRE  = tt_pkg::TT_NUM_PRE,
  localparam int SEL_W    = tt_pkg::TT_SEL_W,
  localparam int DATA_W   = tt_pkg::TT_DATA_W,
  localparam int NIB_W    = DATA_W / 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_addr,
  input  logic [NIB_W-1:0]   cfg_nib_en,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic [NUM_PRE-1:0] ext_clk_in,
  output logic [NUM_TMR-1:0] tick_o
);
  logic [NUM_PRE-1:0][PRE_W-1:0] pre_val;
  logic [NUM_PRE-1:0][PRE_W-1:0] pre_cnt;
  logic [NUM_TMR-1:0][SEL_W-1:0] sel_val;
  logic [NUM_PRE-1:0]            pre_clr;
  logic [NUM_TMR-1:0]            sel_clr;
  logic [NUM_PRE-1:0]            pre_tick;
  logic [NUM_PRE-1:0]            ext_rise;

  tt_cfg_regs #(
    .NUM_TMR(NUM_TMR), .NUM_PRE(NUM_PRE), .PRE_W(PRE_W),
    .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .nib_en(cfg_nib_en), .wdata(cfg_wdata),
    .pre_val(pre_val), .sel_val(sel_val),
    .pre_clr(pre_clr), .sel_clr(sel_clr)
  );

  for (genvar p = 0; p < NUM_PRE; p++) begin : g_grp
    tt_prescaler #(.W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(pre_clr[p]), .limit(pre_val[p]),
      .tick(pre_tick[p]), .cnt_o(pre_cnt[p])
    );
    tt_ext_sync u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in[p]), .rise(ext_rise[p])
    );
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam int G = (t < GRP0_SIZE) ? 0 : 1;
    tt_chan #(.SEL_W(SEL_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .clr(sel_clr[t] | pre_clr[G]),
      .code(sel_val[t]),
      .pre_tick(pre_tick[G]),
      .ext_rise(ext_rise[G]),
      .tick_q(tick_o[t])
    );
  end
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int NUM_TMR   = 5,
  parameter int PRE_W     = 8,
  parameter int GRP0_SIZE = 2,
  parameter int NUM_PRE   = 2,
  parameter int SEL_W     = 4,
  parameter int NIB_W     = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic                          cfg_addr,
  input logic [NIB_W-1:0]              cfg_nib_en,
  input logic [NUM_TMR-1:0]            tick_o,
  input logic [NUM_PRE-1:0]            pre_tick,
  input logic [NUM_PRE-1:0][PRE_W-1:0] pre_cnt,
  input logic [NUM_PRE-1:0][PRE_W-1:0] pre_val,
  input logic [NUM_TMR-1:0][SEL_W-1:0] sel_val
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> tick_o == '0); // R1

  for (genvar p = 0; p < NUM_PRE; p++) begin : g_p
    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) pre_cnt[p] <= pre_val[p]); // R2
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
    localparam int G = (t < GRP0_SIZE) ? 0 : 1;
    AST_DIV_FOLLOWS_PRE: assert property (@(posedge clk) disable iff (!rst_n) (tick_o[t] && $past(sel_val[t]) < SEL_W'(4) && $past(!cfg_we)) |-> $past(pre_tick[G])); // R3
    AST_EXT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n) (tick_o[t] && sel_val[t] >= SEL_W'(4)) |=> !tick_o[t]); // R6
    AST_FIELD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && !(cfg_addr && cfg_nib_en[t])) |=> $stable(sel_val[t])); // R7
  end
endmodule

bind timer_tick_tree tt_checker #(
  .NUM_TMR(NUM_TMR), .PRE_W(PRE_W), .GRP0_SIZE(GRP0_SIZE),
  .NUM_PRE(NUM_PRE), .SEL_W(SEL_W), .NIB_W(NIB_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_nib_en(cfg_nib_en), .tick_o(tick_o), .pre_tick(pre_tick),
  .pre_cnt(pre_cnt), .pre_val(pre_val), .sel_val(sel_val)
);

// File: tb/timer_tick_tree_tb.sv
module timer_tick_tree_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [7:0]  cfg_nib_en = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  ext_clk_in = '0;
  logic [4:0]  tick_o;

  int     tests = 0;
  int     fails = 0;
  bit     done = 1'b0;
  longint cyc = 0;
  int     tick_cnt [5] = '{default: 0};
  longint last_t [5] = '{default: 0};
  longint per [5] = '{default: 0};
  int     base [5];

  always #5 clk = ~clk;

  timer_tick_tree u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_nib_en(cfg_nib_en), .cfg_wdata(cfg_wdata),
    .ext_clk_in(ext_clk_in), .tick_o(tick_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int t = 0; t < 5; t++) begin
      if (rst_n && tick_o[t]) begin
        per[t]    = cyc - last_t[t];
        last_t[t] = cyc;
        tick_cnt[t]++;
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] ne, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_nib_en = ne; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_nib_en = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap();
    for (int t = 0; t < 5; t++) base[t] = tick_cnt[t];
  endtask

  initial begin
    int plist [4] = '{0, 1, 3, 6};
    // R1: reset state and first ticks
    wait_n(3);
    check("R1 in reset", tick_o, 0);
    rst_n = 1'b1;
    @(negedge clk); check("R1 first edge", tick_o, 5'h00);
    @(negedge clk); check("R1 second edge", tick_o, 5'h1f);
    @(negedge clk); check("R1 third edge", tick_o, 5'h00);
    @(negedge clk); check("R1 fourth edge", tick_o, 5'h1f);

    // R8: restart on select write, P=0, timer0 code 1
    wr(1'b1, 8'h01, 32'h0000_0001);
    check("R8 cleared at write", tick_o[0], 0);
    wait_n(3); check("R8 before first tick", tick_o[0], 0);
    wait_n(1); check("R8 first tick", tick_o[0], 1);

    // R2 R3 R4: sweep of prescale pairs and divider codes
    for (int pi = 0; pi < 4; pi++) begin
      for (int k = 0; k < 4; k++) begin
        int p0;
        int p1;
        logic [31:0] sw;
        p0 = plist[pi];
        p1 = plist[(pi + 1) % 4];
        sw = '0;
        for (int t = 0; t < 5; t++) sw[4*t +: 4] = 4'((t + k) % 4);
        wr(1'b0, 8'hFF, {16'h0, 8'(p1), 8'(p0)});
        wr(1'b1, 8'hFF, sw);
        wait_n(400);
        for (int t = 0; t < 5; t++) begin
          int pg;
          pg = (t < 2) ? p0 : p1;
          check($sformatf("R2 R3 R4 sweep t%0d p=%0d k=%0d", t, pg, k),
                per[t], longint'(pg + 1) * (2 << ((t + k) % 4)));
        end
      end
    end

    // R2: largest prescale values with divide by 16
    wr(1'b0, 8'hFF, 32'h0000_FEFF);
    wr(1'b1, 8'hFF, 32'h0003_3333);
    wait_n(12400);
    check("R2 max A t0", per[0], 4096);
    check("R2 max B t4", per[4], 4080);

    // R7 R5: single-nibble writes
    wr(1'b0, 8'hFF, 32'h0000_0201);
    wr(1'b1, 8'hFF, 32'h0000_0000);
    wait_n(50);
    wr(1'b1, 8'h04, 32'hFFFF_FFFF);
    wait_n(50);
    snap();
    wait_n(100);
    check("R5 code15 quiet pin", tick_cnt[2] - base[2], 0);
    check("R7 t0 kept", per[0], 4);
    check("R7 t1 kept", per[1], 4);
    check("R7 t3 kept", per[3], 6);
    check("R7 t4 kept", per[4], 6);
    wr(1'b0, 8'h01, 32'h0000_0003);
    wait_n(100);
    check("R7 prescaler A low nibble", per[0], 8);
    check("R7 prescaler B kept", per[3], 6);

    // R6 R4 R5: external mode on all timers
    wr(1'b1, 8'hFF, 32'h0004_4444);
    wait_n(10);
    snap();
    ext_clk_in[0] = 1'b1;
    @(negedge clk); check("R6 latency edge1", tick_o, 0);
    @(negedge clk); check("R6 latency edge2", tick_o, 0);
    @(negedge clk); check("R6 R4 tick on group A", tick_o, 5'b00011);
    @(negedge clk); check("R6 single cycle", tick_o, 0);
    wait_n(10);
    ext_clk_in[0] = 1'b0;
    wait_n(10);
    check("R6 held high one tick t0", tick_cnt[0] - base[0], 1);
    check("R6 held high one tick t1", tick_cnt[1] - base[1], 1);
    check("R4 pin0 spares t2", tick_cnt[2] - base[2], 0);
    check("R4 pin0 spares t4", tick_cnt[4] - base[4], 0);
    for (int n = 0; n < 3; n++) begin
      ext_clk_in[1] = 1'b1; wait_n(4);
      ext_clk_in[1] = 1'b0; wait_n(4);
    end
    wait_n(10);
    for (int t = 2; t < 5; t++)
      check($sformatf("R4 R5 pin1 t%0d", t), tick_cnt[t] - base[t], 3);
    check("R4 pin1 spares t0", tick_cnt[0] - base[0], 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule